// File: doc/BRIEF.md
# Triggered Pulse Program Controller

This block sequences a pulse-program engine. It holds a program counter, presents that counter as an address to an external program memory, and reads back an opcode and a duration in the same cycle. The opcodes are continue, wait and stop. The block runs until it reaches a wait or a stop. It then parks until a trigger or a reset arrives. What a trigger does depends on why the engine is parked:

- A trigger after a wait resumes at the next instruction.
- A trigger after a reset starts the program from address zero.
- A trigger after a stop does nothing until a reset has been applied.

Trigger and reset requests come from several sources:

- Three hardware trigger pins. One fires on a falling edge and two fire on a rising edge.
- Two hardware reset pins, one asserted high and one asserted low.
- A single-cycle software trigger strobe and a single-cycle software reset strobe.

Every pin passes through a two-flop synchroniser before it is used.

Top module: `pulse_seq_ctrl`

## Requirements
- R1: After the system reset `rst_n` is released, `instr_addr_o` is 0 and `running_o`, `waiting_o` and `stopped_o` are all low.
- R2: The instruction at the current address is held for max(duration,1) clock cycles. For opcode CONTINUE (code 0, and also code 3) the address then advances by one, wrapping from its maximum to 0.
- R3: While idle after a reset (running and stopped both low), a trigger makes `running_o` high at address 0 on the next clock edge.
- R4: When a WAIT (code 1) completes its duration, `running_o` and `waiting_o` are both high and the address holds. A trigger then clears `waiting_o` and moves to the next address, keeping `running_o` high.
- R5: When a STOP (code 2) completes its duration, `stopped_o` goes high and `running_o` and `waiting_o` go low. The address and stop status then hold, and every trigger is ignored, until a reset arrives.
- R6: A trigger that arrives while an instruction is executing (running high, waiting low) has no effect on the address or the status.
- R7: Any reset request aborts execution: software strobe, high reset pin, or low reset pin. It sets the address to 0 and clears running, waiting and stopped. A later trigger restarts the program from address 0.
- R8: When a reset request and a trigger occur in the same cycle, the reset wins and the engine ends idle at address 0.
- R9: `trig_n_i` fires on a falling edge, and `trig_a_i` and `trig_b_i` fire on a rising edge. The effect appears on the third rising clock edge after the pin changes. A pin that is held at its active level does not trigger again.
- R10: The hardware reset pins act on their level. The effect appears on the third rising clock edge after assertion, and the engine stays idle for as long as a pin stays asserted.
- R11: The software strobes `sw_trig_i` and `sw_rst_i` act on the first rising clock edge at which they are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| trig_n_i | input | 1 | Hardware trigger, falling edge fires |
| trig_a_i | input | 1 | Hardware trigger, rising edge fires |
| trig_b_i | input | 1 | Hardware trigger, rising edge fires |
| hwrst_hi_i | input | 1 | Hardware reset, asserted high |
| hwrst_lo_n_i | input | 1 | Hardware reset, asserted low |
| sw_trig_i | input | 1 | Single-cycle software trigger strobe |
| sw_rst_i | input | 1 | Single-cycle software reset strobe |
| instr_addr_o | output | AW | Program memory address (program counter) |
| instr_op_i | input | 2 | Opcode at `instr_addr_o`: 0 continue, 1 wait, 2 stop, 3 continue |
| instr_dur_i | input | DW | Duration count at `instr_addr_o` |
| running_o | output | 1 | Program executing or parked on a wait |
| waiting_o | output | 1 | Parked on a wait |
| stopped_o | output | 1 | Halted by a stop, cleared by reset |

## Verification
A directed program walks through the following, and each step separates one idle reason from the others:
- A long continue, then a zero-length continue.
- A wait, released by a hardware rising edge.
- A continue that receives a software trigger while it executes.
- A stop, followed by a falling-edge trigger.

Coincident software reset and trigger strobes show reset priority. A held low-level reset pin followed by a held trigger level shows that levels do not retrigger. Constrained random programs then mix all opcodes, durations 0 to 7 and opcode 3 with random strobes, edges on each pin and reset pulses. These are compared every cycle against a reference sequencer kept in the bench.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  typedef enum logic [1:0] {
    OP_CONT = 2'd0,
    OP_WAIT = 2'd1,
    OP_STOP = 2'd2,
    OP_CONT_ALT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_WAIT = 2'd2,
    ST_STOP = 2'd3
  } seq_st_e;
endpackage

// File: rtl/pseq_sync.sv
module pseq_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/pseq_edge.sv
module pseq_edge #(
  parameter int W = 1,
  parameter logic [W-1:0] ACT_LOW = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= ACT_LOW;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (ACT_LOW[i]) begin : g_fall
      assign evt[i] = prev_q[i] & ~lvl[i];
    end else begin : g_rise
      assign evt[i] = ~prev_q[i] & lvl[i];
    end
  end
endmodule

// File: rtl/pseq_core.sv
module pseq_core
  import pseq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_evt,
  input  logic          rst_req,
  input  logic [1:0]    op,
  input  logic [DW-1:0] dur,
  output logic [AW-1:0] pc,
  output logic          running,
  output logic          waiting,
  output logic          stopped
);
  seq_st_e       st_q, st_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          st_en, pc_en, cnt_en;
  logic          done;

  assign done = ({1'b0, cnt_q} + 1'b1) >= {1'b0, dur};

  always_comb begin
    st_d  = st_q;
    pc_d  = pc_q;
    cnt_d = cnt_q;
    if (rst_req) begin
      st_d  = ST_IDLE;
      pc_d  = '0;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (trig_evt) begin
            st_d  = ST_EXEC;
            pc_d  = '0;
            cnt_d = '0;
          end
        end
        ST_EXEC: begin
          if (done) begin
            cnt_d = '0;
            if (op == OP_WAIT)      st_d = ST_WAIT;
            else if (op == OP_STOP) st_d = ST_STOP;
            else                    pc_d = pc_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (trig_evt) begin
            st_d  = ST_EXEC;
            pc_d  = pc_q + 1'b1;
            cnt_d = '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign st_en  = (st_d != st_q);
  assign pc_en  = (pc_d != pc_q);
  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pc_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (st_en)  st_q  <= st_d;
      if (pc_en)  pc_q  <= pc_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign pc      = pc_q;
  assign running = (st_q == ST_EXEC) || (st_q == ST_WAIT);
  assign waiting = (st_q == ST_WAIT);
  assign stopped = (st_q == ST_STOP);
endmodule

// File: rtl/pulse_seq_ctrl.sv
module pulse_seq_ctrl #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_n_i,
  input  logic          trig_a_i,
  input  logic          trig_b_i,
  input  logic          hwrst_hi_i,
  input  logic          hwrst_lo_n_i,
  input  logic          sw_trig_i,
  input  logic          sw_rst_i,
  output logic [AW-1:0] instr_addr_o,
  input  logic [1:0]    instr_op_i,
  input  logic [DW-1:0] instr_dur_i,
  output logic          running_o,
  output logic          waiting_o,
  output logic          stopped_o
);
  localparam int NTRIG = 3;
  localparam logic [NTRIG-1:0] TRIG_ACT_LOW = 3'b001;
  localparam int NRST = 2;
  localparam logic [NRST-1:0] RST_IDLE = 2'b10;

  logic [NTRIG-1:0] trig_raw, trig_sync, trig_hit;
  logic [NRST-1:0]  rst_raw, rst_sync;
  logic             hw_rst_lvl;
  logic             trig_evt;
  logic             rst_req;

  assign trig_raw = {trig_b_i, trig_a_i, trig_n_i};
  assign rst_raw  = {hwrst_lo_n_i, hwrst_hi_i};

  pseq_sync #(.W(NTRIG), .RST_VAL(TRIG_ACT_LOW)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .d(trig_raw), .q(trig_sync)
  );

  pseq_edge #(.W(NTRIG), .ACT_LOW(TRIG_ACT_LOW)) u_trig_edge (
    .clk(clk), .rst_n(rst_n), .lvl(trig_sync), .evt(trig_hit)
  );

  pseq_sync #(.W(NRST), .RST_VAL(RST_IDLE)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(rst_raw), .q(rst_sync)
  );

  assign hw_rst_lvl = rst_sync[0] | ~rst_sync[1];
  assign rst_req    = hw_rst_lvl | sw_rst_i;
  assign trig_evt   = (|trig_hit) | sw_trig_i;

  pseq_core #(.AW(AW), .DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .trig_evt(trig_evt), .rst_req(rst_req),
    .op(instr_op_i), .dur(instr_dur_i),
    .pc(instr_addr_o), .running(running_o),
    .waiting(waiting_o), .stopped(stopped_o)
  );
endmodule

// File: rtl/pulse_seq_ctrl_chk.sv
module pulse_seq_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_rst_i,
  input logic [AW-1:0] addr,
  input logic          running,
  input logic          waiting,
  input logic          stopped,
  input logic          trig_evt,
  input logic          rst_req
);
  // R5: stop status excludes the other two
  a_r5_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (!running && !waiting));

  // R4: waiting implies running
  a_r4_wait_runs: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> running);

  a_r4_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !trig_evt && !rst_req) |=> (waiting && $stable(addr)));

  a_r4_wait_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && trig_evt && !rst_req) |=>
      (running && !waiting && addr == AW'($past(addr) + 1'b1)));

  a_r5_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !rst_req) |=> (stopped && $stable(addr)));

  a_r3_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !stopped && trig_evt && !rst_req) |=> (running && addr == '0));

  a_r7_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (!running && !waiting && !stopped && addr == '0));

  a_r8_swrst_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_i |=> (!running && !stopped && addr == '0));
endmodule

bind pulse_seq_ctrl pulse_seq_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst_i(sw_rst_i),
  .addr(instr_addr_o), .running(running_o), .waiting(waiting_o),
  .stopped(stopped_o), .trig_evt(trig_evt), .rst_req(rst_req)
);

// File: tb/pulse_seq_ctrl_bench.sv
module pulse_seq_ctrl_bench;
  localparam int AW = 4;
  localparam int DW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic trig_n, trig_a, trig_b, hwrst_hi, hwrst_lo_n, sw_trig, sw_rst;
  logic [AW-1:0] addr;
  logic [1:0]    op;
  logic [DW-1:0] dur;
  logic running, waiting, stopped;

  logic [1:0]    op_mem  [DEPTH];
  logic [DW-1:0] dur_mem [DEPTH];

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model state
  logic [2:0] m_t1, m_t2, m_t3;
  logic       m_r1, m_r2;
  int         m_st, m_pc, m_cnt;

  always #2 clk = ~clk;

  assign op  = op_mem[addr];
  assign dur = dur_mem[addr];

  pulse_seq_ctrl #(.AW(AW), .DW(DW)) u_pulse_seq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .trig_n_i(trig_n), .trig_a_i(trig_a), .trig_b_i(trig_b),
    .hwrst_hi_i(hwrst_hi), .hwrst_lo_n_i(hwrst_lo_n),
    .sw_trig_i(sw_trig), .sw_rst_i(sw_rst),
    .instr_addr_o(addr), .instr_op_i(op), .instr_dur_i(dur),
    .running_o(running), .waiting_o(waiting), .stopped_o(stopped)
  );

  // model: 0 idle, 1 exec, 2 wait, 3 stop
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t1 <= '0; m_t2 <= '0; m_t3 <= '0;
      m_r1 <= 1'b0; m_r2 <= 1'b0;
      m_st <= 0; m_pc <= 0; m_cnt <= 0;
    end else begin
      bit tg, rr;
      tg = (|(m_t2 & ~m_t3)) | sw_trig;
      rr = m_r2 | sw_rst;
      m_t1 <= {trig_b, trig_a, ~trig_n};
      m_t2 <= m_t1;
      m_t3 <= m_t2;
      m_r1 <= hwrst_hi | ~hwrst_lo_n;
      m_r2 <= m_r1;
      if (rr) begin
        m_st <= 0; m_pc <= 0; m_cnt <= 0;
      end else begin
        case (m_st)
          0: if (tg) begin m_st <= 1; m_pc <= 0; m_cnt <= 0; end
          1: begin
            if (m_cnt + 1 >= int'(dur_mem[m_pc])) begin
              m_cnt <= 0;
              if (op_mem[m_pc] == 2'd1)      m_st <= 2;
              else if (op_mem[m_pc] == 2'd2) m_st <= 3;
              else                           m_pc <= (m_pc + 1) % DEPTH;
            end else begin
              m_cnt <= m_cnt + 1;
            end
          end
          2: if (tg) begin m_st <= 1; m_pc <= (m_pc + 1) % DEPTH; m_cnt <= 0; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [2:0] exp_status(int st);
    return {st == 3, st == 2, (st == 1) || (st == 2)};
  endfunction

  task automatic compare_model();
    logic [2:0] e, a;
    e = exp_status(m_st);
    a = {stopped, waiting, running};
    vectors++;
    if (a != e || int'(addr) != m_pc) begin
      fails++;
      $display("FAIL %s: addr/stop/wait/run actual %0d/%b expected %0d/%b",
               cur_req, addr, a, m_pc, e);
    end
  endtask

  task automatic check(bit ok, string req, int act, int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare_model();
    sw_trig = 1'b0;
    sw_rst  = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < DEPTH; i++) begin
      op_mem[i] = 2'd0;
      dur_mem[i] = 3'd1;
    end
    op_mem[0] = 2'd0; dur_mem[0] = 3'd2;
    op_mem[1] = 2'd0; dur_mem[1] = 3'd0;
    op_mem[2] = 2'd1; dur_mem[2] = 3'd1;
    op_mem[3] = 2'd0; dur_mem[3] = 3'd1;
    op_mem[4] = 2'd2; dur_mem[4] = 3'd2;

    trig_n = 1'b1; trig_a = 1'b0; trig_b = 1'b0;
    hwrst_hi = 1'b0; hwrst_lo_n = 1'b1; sw_trig = 1'b0; sw_rst = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cur_req = "R1";
    tick();
    check(addr == 0 && !running && !waiting && !stopped, "R1",
          {stopped, waiting, running}, 0);

    // R3 / R11: software trigger starts at 0
    cur_req = "R3";
    sw_trig = 1'b1;
    tick();
    check(running && addr == 0, "R11", int'(running), 1);
    // R2: two cycles at addr 0, zero-length at addr 1
    cur_req = "R2";
    tick();
    tick();
    check(addr == 1, "R2", int'(addr), 1);
    tick();
    check(addr == 2 && !waiting, "R2", int'(addr), 2);
    // R4: wait parks
    cur_req = "R4";
    tick();
    check(waiting && running && addr == 2, "R4", {waiting, running}, 3);
    ticks(3);
    check(waiting && addr == 2, "R4", int'(waiting), 1);
    // R9: rising edge on trig_a, acts on third edge
    cur_req = "R9";
    trig_a = 1'b1;
    tick();
    tick();
    check(waiting, "R9", int'(waiting), 1);
    tick();
    check(!waiting && running && addr == 3, "R9", int'(addr), 3);
    // R6: trigger during execution is ignored
    cur_req = "R6";
    sw_trig = 1'b1;
    tick();
    check(addr == 4 && running && !waiting, "R6", int'(addr), 4);
    // R5: stop after its duration, triggers ignored
    cur_req = "R5";
    tick();
    tick();
    check(stopped && !running && !waiting && addr == 4, "R5", int'(stopped), 1);
    trig_n = 1'b0;
    ticks(5);
    sw_trig = 1'b1;
    tick();
    check(stopped && addr == 4, "R5", int'(stopped), 1);
    trig_n = 1'b1;
    ticks(4);
    // R8: reset and trigger together
    cur_req = "R8";
    sw_rst = 1'b1; sw_trig = 1'b1;
    tick();
    check(!running && !stopped && addr == 0, "R8", int'(running), 0);
    ticks(2);
    check(!running && !stopped, "R8", int'(running), 0);
    // R7 / R10: low-level hardware reset while running
    cur_req = "R7";
    sw_trig = 1'b1;
    tick();
    tick();
    check(running, "R7", int'(running), 1);
    hwrst_lo_n = 1'b0;
    tick();
    tick();
    tick();
    check(!running && !stopped && !waiting && addr == 0, "R7", int'(running), 0);
    cur_req = "R10";
    sw_trig = 1'b1;
    tick();
    check(!running && addr == 0, "R10", int'(running), 0);
    hwrst_lo_n = 1'b1;
    ticks(4);
    // R9: trig_a is still held high, so no retrigger
    cur_req = "R9";
    check(!running, "R9", int'(running), 0);
    cur_req = "R7";
    sw_trig = 1'b1;
    tick();
    check(running && addr == 0, "R7", int'(running), 1);
    // R10: high-level reset pin
    cur_req = "R10";
    hwrst_hi = 1'b1;
    ticks(3);
    check(!running && addr == 0, "R10", int'(running), 0);
    hwrst_hi = 1'b0;
    trig_a = 1'b0;
    ticks(4);

    // constrained random phase
    cur_req = "R2";
    for (int i = 0; i < DEPTH; i++) begin
      int r;
      r = int'($urandom % 8);
      op_mem[i]  = (r < 5) ? 2'd0 : (r == 5) ? 2'd1 : (r == 6) ? 2'd2 : 2'd3;
      dur_mem[i] = DW'($urandom % 8);
    end
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 3)        sw_trig = 1'b1;
      else if (r == 3)  sw_rst = 1'b1;
      else if (r < 6)   trig_n = ~trig_n;
      else if (r < 8)   trig_a = ~trig_a;
      else if (r < 10)  trig_b = ~trig_b;
      else if (r == 10) hwrst_hi = 1'b1;
      else if (r == 11) hwrst_lo_n = 1'b0;
      else if (r < 40) begin
        hwrst_hi = 1'b0;
        hwrst_lo_n = 1'b1;
      end
      if (n % 1500 == 1499) begin
        for (int i = 0; i < DEPTH; i++) begin
          int q;
          q = int'($urandom % 8);
          op_mem[i]  = (q < 5) ? 2'd0 : (q == 5) ? 2'd1 : (q == 6) ? 2'd2 : 2'd3;
          dur_mem[i] = DW'($urandom % 8);
        end
      end
      tick();
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule